// File: doc/BRIEF.md
# Bit-Serial Eight-Bit ALU with Persistent Flags

This block is the arithmetic unit of a deliberately slow, visible processor. It takes two 8-bit operands and a 3-bit operation code on a start pulse. Every operation except the left shift then runs one bit per enabled step through a single one-bit slice, least significant bit first. The slice keeps its running carry in one flip-flop. The left shift is wired in parallel and completes without any steps.

The result register fills from the top as bits are produced, so it holds the full answer after the eighth step. A one-cycle done pulse marks completion. Carry, zero and negative flags live in the block and persist between operations, so a later add-with-carry or subtract-with-borrow can chain on an earlier result. Fetching the operands and writing the result back are left to the surrounding sequencer.

Top module: `serial_alu8`

## Requirements
- R1: Operation codes are 0 AND, 1 OR, 2 XOR, 3 shift-left, 4 ADD, 5 ADDC, 6 SUB, 7 SUBC. At done, `result` holds the bitwise AND, OR or XOR of `a` and `b` for codes 0 to 2.
- R2: Code 3 gives `result` = `a` shifted left by one with a 0 in bit 0, and `carry` = `a[7]`. `done` is high in the cycle right after the start edge, with no step needed.
- R3: A serial operation (every code but 3) completes on exactly the eighth step taken while `busy`. `done` is high for exactly one cycle after that edge, and `busy` falls at the same edge.
- R4: ADD gives `a+b` and SUB gives `a+~b+1`, both modulo 256, whatever the stored carry is. `carry` becomes bit 8 of that sum, so for SUB it is 1 when no borrow occurred.
- R5: ADDC gives `a+b+carry` and SUBC gives `a+~b+carry`, using the stored carry as the carry-in (a not-borrow for SUBC). `carry` becomes bit 8 of the sum.
- R6: At every done, `zero` is 1 exactly when `result` is 0, and `neg` equals `result[7]`.
- R7: Codes 0 to 2 leave `carry` unchanged.
- R8: `step` while idle has no effect, and `start` while busy is ignored. The operation in progress finishes with its original operands and code.
- R9: After reset `result`, `carry`, `zero`, `neg`, `done` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| op | input | 3 | Operation code, sampled with start |
| a | input | 8 | First operand, sampled with start |
| b | input | 8 | Second operand, sampled with start |
| step | input | 1 | Advance a serial operation by one bit |
| result | output | 8 | Result register |
| done | output | 1 | One-cycle pulse after completion |
| carry | output | 1 | Stored carry flag |
| zero | output | 1 | Result-was-zero flag |
| neg | output | 1 | Result bit 7 flag |
| busy | output | 1 | Serial operation in progress |

## Verification
A shift is due one clock after its start edge, so the bench samples `done`, `result` and the flags at the falling edge after that single rising edge. A serial result is due one clock after the eighth rising edge at which `step` and `busy` were both high. The bench inserts random idle gaps between steps and counts only the accepted steps. It samples at each falling edge until `done` is seen, then checks that the count is eight and that `done` has dropped one cycle later. Tests of ignored inputs sample the outputs one falling edge after the ignored stimulus and before any new start.

// File: rtl/serial_alu8.sv
module serial_alu8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         step,
  output logic [W-1:0] result,
  output logic         done,
  output logic         carry,
  output logic         zero,
  output logic         neg,
  output logic         busy
);
  localparam int CW = $clog2(W);
  localparam logic [2:0] OP_SHL = 3'd3;

  logic [W-1:0]  sa, sb;
  logic [2:0]    opr;
  logic [CW-1:0] cnt;
  logic          cy;

  wire           arith = opr[2];
  wire           fa    = sa[0];
  wire           fb    = sb[0] ^ (arith & opr[1]);
  wire           cout  = (fa & fb) | (cy & (fa ^ fb));
  wire           last  = (cnt == CW'(W - 1));
  wire [W-1:0]   shl   = {a[W-2:0], 1'b0};
  logic          sbit;
  logic [W-1:0]  nres;

  always_comb begin
    case (opr)
      3'd0:    sbit = fa & fb;
      3'd1:    sbit = fa | fb;
      3'd2:    sbit = fa ^ fb;
      default: sbit = fa ^ fb ^ cy;
    endcase
    nres = {sbit, result[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      sa     <= '0;
      sb     <= '0;
      opr    <= '0;
      cnt    <= '0;
      cy     <= 1'b0;
      done   <= 1'b0;
      carry  <= 1'b0;
      zero   <= 1'b0;
      neg    <= 1'b0;
      busy   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        opr <= op;
        if (op == OP_SHL) begin
          result <= shl;
          carry  <= a[W-1];
          zero   <= (shl == '0);
          neg    <= shl[W-1];
          done   <= 1'b1;
        end else begin
          busy <= 1'b1;
          sa   <= a;
          sb   <= b;
          cnt  <= '0;
          cy   <= op[0] ? carry : op[1];
        end
      end else if (busy && step) begin
        sa     <= sa >> 1;
        sb     <= sb >> 1;
        result <= nres;
        cy     <= cout;
        cnt    <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          zero <= (nres == '0);
          neg  <= nres[W-1];
          if (arith) carry <= cout;
        end
      end
    end
  end
endmodule

// File: rtl/serial_alu8_chk.sv
module serial_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op,
  input logic         step,
  input logic [W-1:0] result,
  input logic         done,
  input logic         carry,
  input logic         zero,
  input logic         neg,
  input logic         busy
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step |=> busy && $stable(result));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> zero == (result == '0));

  assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> neg == result[W-1]);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result) && $stable(carry) && !busy && !done);

  assert_logic_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !op[2] && op != 3'd3 |=> $stable(carry));
endmodule

bind serial_alu8 serial_alu8_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .step(step),
  .result(result), .done(done), .carry(carry), .zero(zero), .neg(neg),
  .busy(busy)
);

// File: tb/test_serial_alu8.sv
module test_serial_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       step = 1'b0;
  logic [7:0] result;
  logic       done, carry, zero, neg, busy;

  int total = 0;
  int bad = 0;
  logic exp_c = 1'b0;

  always #4 clk = ~clk;

  serial_alu8 i_serial_alu8 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .step(step), .result(result), .done(done), .carry(carry), .zero(zero),
    .neg(neg), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [2:0] o, input logic [7:0] x,
                                       input logic [7:0] y, input logic c);
    case (o)
      3'd0: return {c, x & y};
      3'd1: return {c, x | y};
      3'd2: return {c, x ^ y};
      3'd3: return {x[7], x[6:0], 1'b0};
      3'd4: return {1'b0, x} + {1'b0, y};
      3'd5: return {1'b0, x} + {1'b0, y} + 9'(c);
      3'd6: return {1'b0, x} + {1'b0, ~y} + 9'd1;
      default: return {1'b0, x} + {1'b0, ~y} + 9'(c);
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4, 3'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [7:0] x,
                        input logic [7:0] y, input bit gaps, input bit intrude);
    logic [8:0] e;
    int steps;
    e = model(o, x, y, exp_c);
    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = $urandom; a = $urandom; b = $urandom;
    steps = 0;
    if (o != 3'd3) begin
      for (int i = 0; i < 200 && !done; i++) begin
        logic bw;
        bw = busy;
        step = gaps ? ($urandom % 3 != 0) : 1'b1;
        if (intrude && steps == 3) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bw && step) steps++;
      end
      step = 1'b0;
      chk(steps == 8, "R3 step count", steps, 8);
      chk(!busy, "R3 busy low at done", busy, 0);
    end
    chk(done, {rtag(o), " done"}, done, 1);
    chk(result == e[7:0], {rtag(o), " result"}, result, e[7:0]);
    chk(carry == e[8], (o < 3) ? "R7 carry kept" : {rtag(o), " carry"}, carry, e[8]);
    chk(zero == (e[7:0] == 0), "R6 zero", zero, e[7:0] == 0);
    chk(neg == e[7], "R6 neg", neg, e[7]);
    exp_c = e[8];
    @(negedge clk);
    chk(!done, "R3 done pulse width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(result == 0 && carry == 0 && zero == 0 && neg == 0 && done == 0 && busy == 0,
        "R9 reset state", {result, carry, zero, neg, done, busy}, 0);
    rst_n = 1'b1;

    run_op(3'd0, 8'hF0, 8'h3C, 0, 0);
    run_op(3'd1, 8'hA0, 8'h05, 0, 0);
    run_op(3'd2, 8'hFF, 8'hFF, 0, 0);
    run_op(3'd3, 8'h81, 8'h00, 0, 0);
    run_op(3'd3, 8'h80, 8'h00, 0, 0);
    run_op(3'd1, 8'h00, 8'h00, 0, 0);
    run_op(3'd4, 8'hFF, 8'h01, 0, 0);
    run_op(3'd4, 8'h10, 8'h20, 0, 0);
    run_op(3'd3, 8'h80, 8'h00, 0, 0);
    run_op(3'd5, 8'h00, 8'h00, 0, 0);
    run_op(3'd6, 8'h03, 8'h05, 0, 0);
    run_op(3'd7, 8'h05, 8'h03, 0, 0);
    run_op(3'd6, 8'h05, 8'h05, 0, 0);
    run_op(3'd7, 8'h00, 8'h00, 1, 0);

    run_op(3'd4, 8'h11, 8'h22, 1, 1);

    begin
      logic [7:0] r0;
      logic c0;
      r0 = result; c0 = carry;
      @(negedge clk);
      step = 1'b1;
      repeat (5) @(negedge clk);
      step = 1'b0;
      chk(result == r0, "R8 idle step result", result, r0);
      chk(carry == c0, "R8 idle step carry", carry, c0);
      chk(!busy && !done, "R8 idle step state", {busy, done}, 0);
    end

    for (int n = 0; n < 300; n++) begin
      logic [2:0] o;
      o = $urandom;
      run_op(o, $urandom, $urandom, 1, ($urandom % 8) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule